// File: doc/BRIEF.md
# Way-Predicting Set-Associative Data Cache

This block is an N-way set-associative data cache that saves array energy by guessing which way holds the requested word. A small predictor table is read at request acceptance. Its index is the request's set bits XORed with a global history of recently used way numbers. The first probe cycle enables only the guessed way's tag and data banks. When that probe hits, the access completes like a direct-mapped lookup. When it does not, a second probe cycle enables every other way. If the line is found there, the access completes and the predictor entry is retrained with the way that matched.

If neither probe finds the line, a victim way is drawn from a free-running LFSR. A dirty victim is first written back to lower memory, and then the line is refilled. Write misses allocate the line and merge the byte-enabled write data into the fill data. Lines are one 32-bit word, and addresses are word addresses. Three saturating counters report predicted hits, mispredicted hits and misses.

Top module: `wp_cache`

## Requirements
- R1: During and right after reset, reqReady is 1, rspValid and memReq are 0, and all three counters read 0.
- R2: A hit in the predicted way gives rspValid in the first cycle after acceptance. In that cycle exactly one bit of bankEn is set, no lower-memory request is made, and cntPredHit rises by one.
- R3: A hit found in a non-predicted way gives rspValid in the second cycle after acceptance. The first cycle enables one bank and the second enables exactly WAYS-1 banks. No lower-memory request is made, and cntMispHit rises by one.
- R4: On a miss, both probe cycles come first. Then a lower-memory read (memWe=0) is issued, and rspValid is given in the cycle memAck is seen. cntMiss rises by one and always equals the number of completed refill reads (saturated).
- R5: Read data always equals the most recent value written to that address, where a write updates only the bytes whose reqBe bit is 1 (bit b covers data bits 8b+7:8b).
- R6: Write hits cause no lower-memory traffic. A dirty victim is written back (memWe=1), held until memAck, and carries the latest written value, before the refill read of the same access.
- R7: When one resident address is accessed repeatedly with no other access in between, the fifth and later such accesses are predicted hits.
- R8: reqReady is 0 from the cycle after acceptance until the response cycle, including while waiting on lower memory, and it returns to 1 the cycle after rspValid.
- R9: Each counter stops at its all-ones value and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | CPU request present |
| reqReady | output | 1 | Cache can accept a request |
| reqWe | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address; low log2(SETS) bits select the set |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte enables for writes |
| rspValid | output | 1 | Access completes this cycle |
| rspRdata | output | 32 | Read data, valid with rspValid |
| bankEn | output | WAYS | Ways whose banks are read this cycle |
| memReq | output | 1 | Lower-memory request |
| memWe | output | 1 | 1 = write-back, 0 = refill read |
| memAddr | output | ADDR_W | Lower-memory word address |
| memWdata | output | 32 | Write-back data |
| memRdata | input | 32 | Refill data, valid with memAck |
| memAck | input | 1 | Lower memory completes the request |
| cntPredHit | output | CNT_W | Predicted-hit count |
| cntMispHit | output | CNT_W | Mispredicted-hit count |
| cntMiss | output | CNT_W | Miss count |

## Verification
The hardest cases to reach from the ports are a mispredicted hit and an eviction of a dirty line. Each needs several lines to share a set while the history register points the predictor at a stale entry. The stimulus confines a long mixed read/write sequence to two sets and six tags, so the four ways overflow, lines move around and the history keeps changing. Every access is classified by its latency, its bankEn pattern and its memory traffic. Write-back data is compared against the reference model's value for the evicted address. Coverage checks then require that mispredicted hits and write-backs actually occurred.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRED, ST_REST, ST_VICT, ST_WB, ST_FILL
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;       // capture request, read predictor
    logic probePred;   // predicted way banks enabled
    logic probeRest;   // all other ways enabled
    logic commit;      // hit completes this cycle
    logic pickVictim;  // sample LFSR for victim way
    logic wbPhase;     // lower memory sees victim address
    logic fillDone;    // refill data arrives this cycle
  } ctrl_t;
endpackage

// File: rtl/wp_cache_ctl.sv
module wp_cache_ctl
  import wp_cache_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  input  logic  hitPred,
  input  logic  hitRest,
  input  logic  victimDirty,
  input  logic  memAck,
  output ctrl_t ctl,
  output logic  reqReady,
  output logic  rspValid,
  output logic  memReq,
  output logic  memWe
);
  state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    reqReady  = 1'b0;
    rspValid  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latch = 1'b1;
          stateNext = ST_PRED;
        end
      end
      ST_PRED: begin
        ctl.probePred = 1'b1;
        if (hitPred) begin
          ctl.commit = 1'b1;
          rspValid   = 1'b1;
          stateNext  = ST_IDLE;
        end else if (WAYS > 1) begin
          stateNext = ST_REST;
        end else begin
          ctl.pickVictim = 1'b1;
          stateNext      = ST_VICT;
        end
      end
      ST_REST: begin
        ctl.probeRest = 1'b1;
        if (hitRest) begin
          ctl.commit = 1'b1;
          rspValid   = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          ctl.pickVictim = 1'b1;
          stateNext      = ST_VICT;
        end
      end
      ST_VICT: stateNext = victimDirty ? ST_WB : ST_FILL;
      ST_WB: begin
        ctl.wbPhase = 1'b1;
        memReq      = 1'b1;
        memWe       = 1'b1;
        if (memAck) stateNext = ST_FILL;
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.fillDone = 1'b1;
          rspValid     = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/wp_cache_dp.sv
module wp_cache_dp
  import wp_cache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWe,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqBe,
  output logic              hitPred,
  output logic              hitRest,
  output logic              victimDirty,
  output logic [31:0]       rspRdata,
  output logic [WAYS-1:0]   bankEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic [CNT_W-1:0]  cntPredHit,
  output logic [CNT_W-1:0]  cntMispHit,
  output logic [CNT_W-1:0]  cntMiss
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int PT_W  = IDX_W + 1;      // table holds twice the set count
  localparam int PT_N  = 2 * SETS;

  logic [TAG_W-1:0] tagArr  [WAYS][SETS];
  logic [31:0]      dataArr [WAYS][SETS];
  logic [WAYS-1:0]  validArr[SETS];
  logic [WAYS-1:0]  dirtyArr[SETS];
  logic [WAY_W-1:0] predTbl [PT_N];

  logic [PT_W-1:0]   ghr, tblIdx, tblIdxQ;
  logic [7:0]        lfsr;
  logic [ADDR_W-1:0] addrQ;
  logic              weQ;
  logic [31:0]       wdataQ, oldData, merged;
  logic [3:0]        beQ;
  logic [WAY_W-1:0]  predWay, victimWay, restWay, doneWay;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;

  assign idx    = addrQ[IDX_W-1:0];
  assign tag    = addrQ[ADDR_W-1:IDX_W];
  assign tblIdx = {1'b0, reqAddr[IDX_W-1:0]} ^ ghr;

  assign hitPred = validArr[idx][predWay] && (tagArr[predWay][idx] == tag);

  always_comb begin
    hitRest = 1'b0;
    restWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (w[WAY_W-1:0] != predWay && validArr[idx][w] && tagArr[w][idx] == tag) begin
        hitRest = 1'b1;
        restWay = w[WAY_W-1:0];
      end
    end
  end

  assign doneWay = ctl.fillDone ? victimWay : (ctl.probeRest ? restWay : predWay);
  assign oldData = dataArr[doneWay][idx];

  always_comb begin
    for (int b = 0; b < 4; b++)
      merged[b*8 +: 8] = beQ[b] ? wdataQ[b*8 +: 8]
                       : (ctl.fillDone ? memRdata[b*8 +: 8] : oldData[b*8 +: 8]);
  end

  assign rspRdata = ctl.fillDone ? memRdata : oldData;

  always_comb begin
    bankEn = '0;
    if (ctl.probePred) bankEn[predWay] = 1'b1;
    if (ctl.probeRest) begin
      bankEn          = '1;
      bankEn[predWay] = 1'b0;
    end
  end

  assign victimDirty = validArr[idx][victimWay] && dirtyArr[idx][victimWay];
  assign memAddr     = ctl.wbPhase ? {tagArr[victimWay][idx], idx} : addrQ;
  assign memWdata    = dataArr[victimWay][idx];

  // storage arrays: no reset
  always_ff @(posedge clk) begin
    if ((ctl.commit && weQ) || ctl.fillDone)
      dataArr[doneWay][idx] <= weQ ? merged : memRdata;
    if (ctl.fillDone)
      tagArr[victimWay][idx] <= tag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
      end
      for (int p = 0; p < PT_N; p++) predTbl[p] <= '0;
      ghr        <= '0;
      tblIdxQ    <= '0;
      lfsr       <= 8'h5A;
      addrQ      <= '0;
      weQ        <= 1'b0;
      wdataQ     <= '0;
      beQ        <= '0;
      predWay    <= '0;
      victimWay  <= '0;
      cntPredHit <= '0;
      cntMispHit <= '0;
      cntMiss    <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (ctl.latch) begin
        addrQ   <= reqAddr;
        weQ     <= reqWe;
        wdataQ  <= reqWdata;
        beQ     <= reqBe;
        tblIdxQ <= tblIdx;
        predWay <= (WAYS == 1) ? '0 : predTbl[tblIdx];
      end
      if (ctl.pickVictim)
        victimWay <= (WAYS == 1) ? '0 : lfsr[WAY_W-1:0];
      if (ctl.commit || ctl.fillDone) begin
        predTbl[tblIdxQ] <= doneWay;
        ghr              <= PT_W'({ghr, doneWay});
      end
      if (ctl.commit && weQ) dirtyArr[idx][doneWay] <= 1'b1;
      if (ctl.fillDone) begin
        validArr[idx][victimWay] <= 1'b1;
        dirtyArr[idx][victimWay] <= weQ;
      end
      if (ctl.commit && ctl.probePred && cntPredHit != '1) cntPredHit <= cntPredHit + 1'b1;
      if (ctl.commit && ctl.probeRest && cntMispHit != '1) cntMispHit <= cntMispHit + 1'b1;
      if (ctl.fillDone && cntMiss != '1) cntMiss <= cntMiss + 1'b1;
    end
  end
endmodule

// File: rtl/wp_cache.sv
module wp_cache
  import wp_cache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqBe,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic [WAYS-1:0]   bankEn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic [CNT_W-1:0]  cntPredHit,
  output logic [CNT_W-1:0]  cntMispHit,
  output logic [CNT_W-1:0]  cntMiss
);
  ctrl_t ctl;
  logic  hitPred, hitRest, victimDirty;

  wp_cache_ctl #(.WAYS(WAYS)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hitPred(hitPred),
    .hitRest(hitRest), .victimDirty(victimDirty), .memAck(memAck), .ctl(ctl),
    .reqReady(reqReady), .rspValid(rspValid), .memReq(memReq), .memWe(memWe)
  );

  wp_cache_dp #(.ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWe(reqWe),
    .reqWdata(reqWdata), .reqBe(reqBe), .hitPred(hitPred), .hitRest(hitRest),
    .victimDirty(victimDirty), .rspRdata(rspRdata), .bankEn(bankEn),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .cntPredHit(cntPredHit), .cntMispHit(cntMispHit), .cntMiss(cntMiss)
  );
endmodule

// File: rtl/wp_cache_chk.sv
module wp_cache_chk #(
  parameter int WAYS  = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             memReq,
  input logic             memWe,
  input logic             memAck,
  input logic [WAYS-1:0]  bankEn,
  input logic [CNT_W-1:0] cntPredHit,
  input logic [CNT_W-1:0] cntMispHit,
  input logic [CNT_W-1:0] cntMiss
);
  AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);  // R8
  AST_ACCEPT_ONE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> $onehot(bankEn) && !reqReady);  // R2
  AST_BANK_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(bankEn) <= 1 || $countones(bankEn) == WAYS - 1);  // R3
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && !memAck |=> memReq && memWe);  // R6
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck |=> memReq && !memWe);  // R6
  AST_FILL_RSP: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAck |-> rspValid);  // R4
  AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cntMiss >= $past(cntMiss) && cntPredHit >= $past(cntPredHit)
             && cntMispHit >= $past(cntMispHit));  // R9
endmodule

bind wp_cache wp_cache_chk #(.WAYS(WAYS), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/wp_cache_bench.sv
module wp_cache_bench;
  localparam int ADDR_W  = 12;
  localparam int WAYS    = 4;
  localparam int SETS    = 8;
  localparam int CNT_W   = 5;
  localparam int MAXC    = (1 << CNT_W) - 1;
  localparam int MEM_LAT = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWe = 1'b0, memAck = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0] reqWdata = '0, memRdata = '0;
  logic [3:0] reqBe = '0;
  logic reqReady, rspValid, memReq, memWe;
  logic [31:0] rspRdata, memWdata;
  logic [ADDR_W-1:0] memAddr;
  logic [WAYS-1:0] bankEn;
  logic [CNT_W-1:0] cntPredHit, cntMispHit, cntMiss;

  wp_cache #(.ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u_wp_cache (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int fillCnt = 0, wbCnt = 0, memWait = 0;
  int predCnt = 0, mispCnt = 0, missCnt = 0;
  int lastKind = 0;  // 1 pred hit, 2 misp hit, 3 miss
  bit ackWrite = 1'b0;
  logic [31:0] refMem [int];
  logic [31:0] lowMem [int];

  function automatic logic [31:0] defVal(int a);
    return (a * 32'h9E3779B1) ^ 32'h00001234;
  endfunction
  function automatic logic [31:0] getRef(int a);
    return refMem.exists(a) ? refMem[a] : defVal(a);
  endfunction
  function automatic logic [31:0] getLow(int a);
    return lowMem.exists(a) ? lowMem[a] : defVal(a);
  endfunction
  function automatic int sat(int x);
    return (x > MAXC) ? MAXC : x;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ideal lower memory plus per-clock counter compare
  always @(negedge clk) begin
    if (rstN) begin
      if (memAck) begin
        memAck  = 1'b0;
        memWait = 0;
        if (ackWrite) wbCnt++;
        else          fillCnt++;
      end else if (memReq) begin
        if (memWait == MEM_LAT) begin
          memAck   = 1'b1;
          ackWrite = memWe;
          if (memWe) begin
            check(memWdata == getRef(int'(memAddr)), "R6 write-back data", memWdata,
                  getRef(int'(memAddr)));
            lowMem[int'(memAddr)] = memWdata;
          end else begin
            memRdata = getLow(int'(memAddr));
          end
        end else memWait++;
      end
      check(int'(cntMiss) == sat(fillCnt), "R4 miss counter vs refills", 32'(cntMiss),
            32'(sat(fillCnt)));
    end
  end

  task automatic access(bit we, logic [ADDR_W-1:0] addr, logic [31:0] wdata, logic [3:0] be);
    int lat = 0, ones1 = 0, ones2 = 0;
    bit sawMem = 0, sawReady = 0, isMiss = 0;
    logic [31:0] rdata = '0, expData;
    @(negedge clk); #1;
    check(reqReady == 1'b1, "R8 ready when idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqWe = we; reqAddr = addr; reqWdata = wdata; reqBe = be;
    @(posedge clk); #1;
    reqValid = 1'b0;
    while (1) begin
      @(negedge clk); #1;
      lat++;
      if (lat == 1) ones1 = $countones(bankEn);
      if (lat == 2) ones2 = $countones(bankEn);
      if (memReq) sawMem = 1;
      if (reqReady) sawReady = 1;
      if (rspValid) begin
        rdata  = rspRdata;
        isMiss = memAck && !memWe;
        break;
      end
      if (lat > 60) begin
        check(1'b0, "R8 response timeout", 32'(lat), 32'd0);
        break;
      end
    end
    check(!sawReady, "R8 ready low while busy", 32'(sawReady), 32'd0);
    if (isMiss) begin
      missCnt++; lastKind = 3;
      check(lat > 2, "R4 miss after both probes", 32'(lat), 32'd3);
    end else if (lat == 1) begin
      predCnt++; lastKind = 1;
      check(ones1 == 1, "R2 one bank on predicted hit", 32'(ones1), 32'd1);
      check(!sawMem, "R2 R6 no memory traffic on hit", 32'(sawMem), 32'd0);
    end else if (lat == 2) begin
      mispCnt++; lastKind = 2;
      check(ones1 == 1 && ones2 == WAYS - 1, "R3 bank pattern on mispredicted hit",
            32'(ones2), 32'(WAYS - 1));
      check(!sawMem, "R3 R6 no memory traffic on hit", 32'(sawMem), 32'd0);
    end else begin
      check(1'b0, "R3 hit latency", 32'(lat), 32'd2);
    end
    if (!we) begin
      expData = getRef(int'(addr));
      check(rdata == expData, "R5 read data", rdata, expData);
    end else begin
      expData = getRef(int'(addr));
      for (int b = 0; b < 4; b++) if (be[b]) expData[b*8 +: 8] = wdata[b*8 +: 8];
      refMem[int'(addr)] = expData;
    end
    @(negedge clk); #1;
    check(reqReady == 1'b1, "R8 ready after response", 32'(reqReady), 32'd1);
    check(int'(cntPredHit) == sat(predCnt), "R2 predicted-hit counter", 32'(cntPredHit),
          32'(sat(predCnt)));
    check(int'(cntMispHit) == sat(mispCnt), "R3 mispredicted-hit counter", 32'(cntMispHit),
          32'(sat(mispCnt)));
    check(int'(cntMiss) == sat(missCnt), "R4 miss counter", 32'(cntMiss), 32'(sat(missCnt)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [ADDR_W-1:0] ADDR_A = 12'h010;

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && rspValid == 1'b0 && memReq == 1'b0, "R1 outputs in reset",
          {29'd0, reqReady, rspValid, memReq}, 32'h4);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(cntPredHit == 0 && cntMispHit == 0 && cntMiss == 0, "R1 counters after reset",
          32'(cntPredHit + cntMispHit + cntMiss), 32'd0);
    check(reqReady == 1'b1, "R1 ready after reset", 32'(reqReady), 32'd1);

    access(1'b0, ADDR_A, 32'd0, 4'h0);
    check(lastKind == 3, "R4 first touch is a miss", 32'(lastKind), 32'd3);
    access(1'b1, ADDR_A, 32'hCAFEF00D, 4'hF);
    access(1'b1, ADDR_A, 32'h00AB0000, 4'b0100);
    access(1'b0, ADDR_A, 32'd0, 4'h0);
    check(refMem[int'(ADDR_A)] == 32'hCAABF00D, "R5 byte merge", refMem[int'(ADDR_A)],
          32'hCAABF00D);
    for (int i = 0; i < 6; i++) begin
      access(1'b0, ADDR_A, 32'd0, 4'h0);
      if (i >= 4) check(lastKind == 1, "R7 trained prediction", 32'(lastKind), 32'd1);
    end

    for (int i = 0; i < 400; i++) begin
      automatic int t = $urandom_range(0, 5);
      automatic int s = $urandom_range(0, 1);
      automatic logic [ADDR_W-1:0] a = ADDR_W'((t << 3) | s);
      automatic bit w = $urandom_range(0, 1) == 1;
      automatic logic [3:0] be = 4'($urandom_range(1, 15));
      access(w, a, $urandom, be);
    end
    check(mispCnt > 0, "R3 mispredicted hits occurred", 32'(mispCnt), 32'd1);
    check(wbCnt > 0, "R6 dirty write-backs occurred", 32'(wbCnt), 32'd1);

    for (int i = 0; i < 40; i++) access(1'b0, ADDR_A, 32'd0, 4'h0);
    check(cntPredHit == '1, "R9 predicted-hit counter saturates", 32'(cntPredHit), 32'(MAXC));
    check(cntMiss == '1, "R9 miss counter saturates", 32'(cntMiss), 32'(MAXC));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule